// File: doc/BRIEF.md
# Push-Button Soft/Hard Reset Controller

This block turns a single active-low push-button into two kinds of reset action, chosen by how long the button is held. A brief press gives a narrow active-low soft-reset pulse. The pulse comes only after the button has been released and has stayed quiet for a debounce interval. A hold that outlasts a long-hold threshold gives a hard-reset request instead. The request stays up for as long as the button is held. The downstream reset sequencer receives this request and adds its own post-release hold time.

Very short presses, even narrower than one clock period, are caught by an edge-triggered capture flop and then synchronised. The slow button level is synchronised on its own path. While the system is already in a supply-induced reset, a press cannot produce a soft pulse. A hold that runs through such a fault still ends in a hard request. The long-hold, debounce and pulse-width durations are separate parameters, all counted in clock cycles.

Top module: `pbr_reset_ctrl`

## Requirements
- R1: After reset `soft_rst_no` is 1 and `hard_req_o` is 0.
- R2: A press shorter than the long-hold threshold produces exactly one soft pulse, seen as `soft_rst_no` = 0, and only after release.
- R3: The soft pulse begins between DEBOUNCE_CYC+1 and DEBOUNCE_CYC+5 cycles after the last release and lasts exactly PULSE_CYC cycles.
- R4: A press narrower than one clock period is still recognised and yields a soft pulse.
- R5: A hold longer than HOLD_CYC cycles raises `hard_req_o` between HOLD_CYC and HOLD_CYC+5 cycles after the press, and that press gives no soft pulse.
- R6: `hard_req_o` stays high for as long as the button is held, even for many times the threshold, because the hold count saturates. It drops 1 to 5 cycles after release.
- R7: While `supply_rst_i` is 1, `soft_rst_no` stays 1 and a short press is discarded.
- R8: A hold that begins during a supply-induced reset and continues after the fault clears still raises `hard_req_o`.
- R9: Button activity during the debounce interval restarts the debounce count. The result is one pulse, timed from the final release.
- R10: A press that arrives while a soft pulse is being output is ignored and gives no second pulse.
- R11: A hold of HOLD_CYC-5 cycles gives a soft pulse. A hold of HOLD_CYC+5 cycles gives a hard request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| btn_ni | input | 1 | Raw push-button, low when pressed |
| supply_rst_i | input | 1 | High while a supply-induced reset is in progress |
| soft_rst_no | output | 1 | Active-low soft-reset pulse |
| hard_req_o | output | 1 | Hard-reset request to the reset sequencer |

## Verification
The bench drives holds just below and just above the long-hold threshold. A design that counted the threshold off by more than a few cycles would give the wrong action on one side of it. It drives sub-cycle glitches, both alone and during a live pulse. A design that only sampled the button would miss the lone glitch. A design that did not drop the glitch during a pulse would fire a second pulse. Release bounce is applied inside the debounce window. A design that did not restart the count would pulse early or twice. Presses under an active supply fault check that no soft pulse leaks through, and that a hold spanning the fault still reaches a hard request.

// File: rtl/pbr_pkg.sv
package pbr_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HELD,
        ST_SETTLE,
        ST_PULSE,
        ST_HARD
    } pbr_state_e;

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/pbr_edge_catch.sv
// Remembers a falling edge of the raw button, however narrow, until the
// clocked side acknowledges it.
module pbr_edge_catch (
    input  logic btn_ni,
    input  logic clr_i,
    output logic seen_o
);
    logic seen_q;

    always_ff @(negedge btn_ni or posedge clr_i) begin
        if (clr_i) seen_q <= 1'b0;
        else       seen_q <= 1'b1;
    end

    assign seen_o = seen_q;
endmodule

// File: rtl/pbr_sync.sv
// Multi-stage synchroniser, one chain per bit.
module pbr_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] stg_d [STAGES];
    logic [WIDTH-1:0] stg_q [STAGES];

    always_comb begin
        stg_d[0] = async_i;
        for (int i = 1; i < STAGES; i++) begin
            stg_d[i] = stg_q[i-1];
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
        end else begin
            for (int i = 0; i < STAGES; i++) stg_q[i] <= stg_d[i];
        end
    end

    assign sync_o = stg_q[STAGES-1];
endmodule

// File: rtl/pbr_reset_ctrl.sv
module pbr_reset_ctrl
    import pbr_pkg::*;
#(
    parameter int HOLD_CYC     = 2000000,
    parameter int DEBOUNCE_CYC = 20000,
    parameter int PULSE_CYC    = 100,
    parameter int SYNC_STAGES  = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic btn_ni,
    input  logic supply_rst_i,
    output logic soft_rst_no,
    output logic hard_req_o
);
    localparam int CNT_MAX = max3(HOLD_CYC, DEBOUNCE_CYC, PULSE_CYC);
    localparam int CNT_W   = $clog2(CNT_MAX + 1);
    localparam logic [CNT_W-1:0] HOLD_LAST   = CNT_W'(HOLD_CYC - 1);
    localparam logic [CNT_W-1:0] SETTLE_LAST = CNT_W'(DEBOUNCE_CYC - 1);
    localparam logic [CNT_W-1:0] PULSE_LAST  = CNT_W'(PULSE_CYC - 1);

    typedef struct packed {
        pbr_state_e       state;
        logic [CNT_W-1:0] cnt;
        logic             ack;
        logic             catch_prev;
    } ctrl_t;

    ctrl_t cur_q, nxt_d;

    logic       catch_raw;
    logic       catch_clr;
    logic [1:0] sync_out;
    logic       btn_low_s;
    logic       catch_s;
    logic       catch_evt;
    logic       activity;

    assign catch_clr = cur_q.ack | ~rst_ni;

    pbr_edge_catch u_catch (
        .btn_ni (btn_ni),
        .clr_i  (catch_clr),
        .seen_o (catch_raw)
    );

    pbr_sync #(
        .WIDTH  (2),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .async_i ({catch_raw, ~btn_ni}),
        .sync_o  (sync_out)
    );

    assign btn_low_s = sync_out[0];
    assign catch_s   = sync_out[1];
    assign catch_evt = catch_s & ~cur_q.catch_prev;
    assign activity  = btn_low_s | catch_evt;

    always_comb begin
        nxt_d            = cur_q;
        nxt_d.ack        = catch_s;
        nxt_d.catch_prev = catch_s;
        unique case (cur_q.state)
            ST_IDLE: begin
                if (activity) begin
                    nxt_d.state = ST_HELD;
                    nxt_d.cnt   = '0;
                end
            end
            ST_HELD: begin
                if (!btn_low_s) begin
                    nxt_d.state = ST_SETTLE;
                    nxt_d.cnt   = '0;
                end else if (cur_q.cnt == HOLD_LAST) begin
                    nxt_d.state = ST_HARD;
                end else begin
                    nxt_d.cnt = cur_q.cnt + 1'b1;
                end
            end
            ST_SETTLE: begin
                if (activity) begin
                    nxt_d.cnt = '0;
                end else if (cur_q.cnt == SETTLE_LAST) begin
                    nxt_d.state = supply_rst_i ? ST_IDLE : ST_PULSE;
                    nxt_d.cnt   = '0;
                end else begin
                    nxt_d.cnt = cur_q.cnt + 1'b1;
                end
            end
            ST_PULSE: begin
                if (cur_q.cnt == PULSE_LAST) begin
                    nxt_d.state = ST_IDLE;
                    nxt_d.cnt   = '0;
                end else begin
                    nxt_d.cnt = cur_q.cnt + 1'b1;
                end
            end
            ST_HARD: begin
                if (!btn_low_s) begin
                    nxt_d.state = ST_IDLE;
                    nxt_d.cnt   = '0;
                end
            end
            default: begin
                nxt_d.state = ST_IDLE;
                nxt_d.cnt   = '0;
            end
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cur_q.state      <= ST_IDLE;
            cur_q.cnt        <= '0;
            cur_q.ack        <= 1'b0;
            cur_q.catch_prev <= 1'b0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign soft_rst_no = ~((cur_q.state == ST_PULSE) & ~supply_rst_i);
    assign hard_req_o  = (cur_q.state == ST_HARD);
endmodule

// File: rtl/pbr_reset_chk.sv
module pbr_reset_chk #(
    parameter int PULSE_CYC = 100
) (
    input logic clk_i,
    input logic rst_ni,
    input logic btn_ni,
    input logic supply_rst_i,
    input logic soft_rst_no,
    input logic hard_req_o
);
    localparam int LW = $clog2(PULSE_CYC + 2) + 1;
    logic [LW-1:0] low_run_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)           low_run_q <= '0;
        else if (!soft_rst_no) low_run_q <= low_run_q + 1'b1;
        else                   low_run_q <= '0;
    end

    // R5
    hard_blocks_soft_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        hard_req_o |-> soft_rst_no);

    // R3
    pulse_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($rose(soft_rst_no) && !$past(supply_rst_i)) |-> (low_run_q == LW'(PULSE_CYC)));

    // R7
    supply_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        supply_rst_i |-> soft_rst_no);

    // R6
    hard_drop_released_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(hard_req_o) |-> btn_ni);

    // R10
    no_back_to_back_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(soft_rst_no) |=> soft_rst_no);

    // R2
    soft_start_clean_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(soft_rst_no) |-> !hard_req_o);
endmodule

bind pbr_reset_ctrl pbr_reset_chk #(.PULSE_CYC(PULSE_CYC)) u_chk (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .btn_ni       (btn_ni),
    .supply_rst_i (supply_rst_i),
    .soft_rst_no  (soft_rst_no),
    .hard_req_o   (hard_req_o)
);

// File: tb/pbr_reset_ctrl_test.sv
module pbr_reset_ctrl_test;
    localparam int CLK_PERIOD = 10;
    localparam int HOLD  = 60;
    localparam int DEB   = 12;
    localparam int PULSE = 6;
    localparam int WDOG  = 150000;
    localparam int K_SOFT = 0;
    localparam int K_HARD = 1;

    logic clk = 1'b0;
    logic rst_ni = 1'b0;
    logic btn_ni = 1'b1;
    logic supply_rst_i = 1'b0;
    logic soft_rst_no;
    logic hard_req_o;

    int cyc = 0;
    int press_cyc = 0;
    int rel_cyc = 0;
    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    typedef struct {
        int    kind;
        string tag;
    } exp_t;
    exp_t sbq[$];

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    pbr_reset_ctrl #(
        .HOLD_CYC(HOLD), .DEBOUNCE_CYC(DEB), .PULSE_CYC(PULSE)
    ) uut (
        .clk_i(clk), .rst_ni(rst_ni), .btn_ni(btn_ni),
        .supply_rst_i(supply_rst_i),
        .soft_rst_no(soft_rst_no), .hard_req_o(hard_req_o)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic void expect_item(input int kind, input string tag);
        exp_t e;
        e.kind = kind;
        e.tag  = tag;
        sbq.push_back(e);
    endfunction

    task automatic press_for(input int n);
        @(posedge clk); #2;
        btn_ni = 1'b0; press_cyc = cyc;
        repeat (n) @(posedge clk);
        #2; btn_ni = 1'b1; rel_cyc = cyc;
    endtask

    task automatic glitch(input bit mark);
        @(posedge clk); #2;
        btn_ni = 1'b0;
        if (mark) begin press_cyc = cyc; end
        #3; btn_ni = 1'b1;
        if (mark) begin rel_cyc = cyc; end
    endtask

    task automatic settle(input string tag);
        repeat (DEB + PULSE + 20) @(posedge clk);
        chk(sbq.size() == 0, tag, sbq.size(), 0);
        sbq.delete();
    endtask

    // Monitor: pops expected events as the design produces them.
    int  soft_start = 0;
    int  soft_delay = 0;
    bit  soft_prev = 1'b1;
    bit  hard_prev = 1'b0;
    always @(negedge clk) begin
        exp_t it;
        if (rst_ni) begin
            if (soft_prev && !soft_rst_no) begin
                soft_start = cyc;
                soft_delay = cyc - rel_cyc;
            end
            if (!soft_prev && soft_rst_no) begin
                if (sbq.size() == 0) begin
                    chk(1'b0, "R2 unexpected soft pulse", 1, 0);
                end else begin
                    it = sbq.pop_front();
                    chk(it.kind == K_SOFT, it.tag, K_SOFT, it.kind);
                    // R3 delay window and width
                    chk(soft_delay >= DEB + 1 && soft_delay <= DEB + 5,
                        {it.tag, " R3 delay"}, soft_delay, DEB + 3);
                    chk(cyc - soft_start == PULSE, {it.tag, " R3 width"},
                        cyc - soft_start, PULSE);
                end
            end
            if (!hard_prev && hard_req_o) begin
                if (sbq.size() == 0) begin
                    chk(1'b0, "R5 unexpected hard request", 1, 0);
                end else begin
                    it = sbq.pop_front();
                    chk(it.kind == K_HARD, it.tag, K_HARD, it.kind);
                    chk(cyc - press_cyc >= HOLD && cyc - press_cyc <= HOLD + 5,
                        {it.tag, " R5 delay"}, cyc - press_cyc, HOLD + 3);
                end
            end
            if (hard_prev && !hard_req_o) begin
                chk(cyc - rel_cyc >= 1 && cyc - rel_cyc <= 5, "R6 drop after release",
                    cyc - rel_cyc, 3);
            end
            soft_prev = soft_rst_no;
            hard_prev = hard_req_o;
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        if (cyc == WDOG) begin
            chk(1'b0, "watchdog", cyc, 0);
            finish_run();
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #2;
        // R1 reset values
        chk(soft_rst_no == 1'b1, "R1 soft idle", soft_rst_no, 1);
        chk(hard_req_o == 1'b0, "R1 hard idle", hard_req_o, 0);
        rst_ni = 1'b1;
        repeat (3) @(posedge clk);
        #2;
        chk(soft_rst_no == 1'b1 && hard_req_o == 1'b0, "R1 after release",
            {soft_rst_no, hard_req_o}, 2);

        // R2 short presses
        expect_item(K_SOFT, "R2 press 10");
        press_for(10);
        settle("R2 press 10 done");
        expect_item(K_SOFT, "R2 press 3");
        press_for(3);
        settle("R2 press 3 done");

        // R4 sub-cycle press
        expect_item(K_SOFT, "R4 glitch");
        glitch(1'b1);
        settle("R4 glitch done");

        // R5 long hold
        expect_item(K_HARD, "R5 long hold");
        press_for(HOLD + 20);
        settle("R5 done");

        // R6 very long hold: request held throughout
        expect_item(K_HARD, "R6 very long hold");
        @(posedge clk); #2;
        btn_ni = 1'b0; press_cyc = cyc;
        repeat (HOLD + 10) @(posedge clk);
        #2;
        chk(hard_req_o == 1'b1, "R6 held mid", hard_req_o, 1);
        repeat (3 * HOLD) @(posedge clk);
        #2;
        chk(hard_req_o == 1'b1 && soft_rst_no == 1'b1, "R6 held late",
            {hard_req_o, soft_rst_no}, 3);
        btn_ni = 1'b1; rel_cyc = cyc;
        settle("R6 done");

        // R7 supply fault blocks soft pulse
        supply_rst_i = 1'b1;
        press_for(10);
        #1;
        chk(soft_rst_no == 1'b1, "R7 soft high", soft_rst_no, 1);
        settle("R7 no pulse");
        supply_rst_i = 1'b0;
        repeat (4) @(posedge clk);

        // R8 hold spanning the supply fault
        supply_rst_i = 1'b1;
        expect_item(K_HARD, "R8 hold across fault");
        @(posedge clk); #2;
        btn_ni = 1'b0; press_cyc = cyc;
        repeat (20) @(posedge clk);
        #2; supply_rst_i = 1'b0;
        repeat (HOLD) @(posedge clk);
        #2; btn_ni = 1'b1; rel_cyc = cyc;
        settle("R8 done");

        // R9 bounce inside debounce window
        expect_item(K_SOFT, "R9 bounce");
        press_for(10);
        repeat (4) @(posedge clk);
        press_for(2);
        repeat (3) @(posedge clk);
        glitch(1'b1);
        settle("R9 single pulse");

        // R10 press during pulse ignored
        expect_item(K_SOFT, "R10 first pulse");
        press_for(10);
        wait (soft_rst_no == 1'b0);
        glitch(1'b0);
        settle("R10 no second pulse");

        // R11 threshold boundary
        expect_item(K_SOFT, "R11 just under");
        press_for(HOLD - 5);
        settle("R11 under done");
        expect_item(K_HARD, "R11 just over");
        press_for(HOLD + 5);
        settle("R11 over done");

        finish_run();
    end
endmodule